// File: doc/BRIEF.md
# Priority-Class FIFO Budget Limiter

This block decides how much of one shared transfer FIFO each of two channel classes, high priority and low priority, may hold at once. A 2-bit budget code selects the split. Each class has its own occupancy counter. The counter goes up on an accepted allocation and down on a release. The per-class ready output stays high only while that class is below its cap. The FIFO storage, the channel arbitration and the data path live elsewhere. This block only grants or withholds permission to allocate, and it reports the live occupancy.

Each class's allocation side is a valid/ready pair. An allocation is taken only in a cycle where valid and ready are both high. The requester keeps valid asserted across back-pressure. Ready depends only on the current count and the budget code, never on valid, so the requester may wait on ready before raising valid. Release strobes are plain pulses and are never back-pressured.

The block also checks the configuration. When `cfg_update` pulses, it tests whether the per-channel maximum depth and the number of active channels in each class fit inside that class's cap. A failure sets a sticky error flag, which software clears with a one-cycle clear strobe. The parameter `DEPTH` must be a multiple of 4 so that every cap is an exact integer.

Top module: `fifo_budget_limiter`

## Requirements
- R1: After reset both counts are 0, both ready outputs are 1 and `cfg_err` is 0.
- R2: With budget code 1, the high-priority cap is DEPTH/4 and the low-priority cap is 3·DEPTH/4. Each count stops at its cap under continuous valid.
- R3: With budget code 2, the high-priority cap is 3·DEPTH/4 and the low-priority cap is DEPTH/4.
- R4: With budget code 3, each class is capped at DEPTH/2.
- R5: With budget code 0, each class may fill to the whole DEPTH.
- R6: A class's ready equals (count < cap). An allocation is accepted only when valid and ready are both high, and it raises the count by exactly 1 on that clock edge. Valid while ready is low leaves the count unchanged.
- R7: An accepted allocation and a release for the same class in the same cycle leave that class's count unchanged.
- R8: A release while the count is 0, with no accepted allocation, is ignored: the count stays 0.
- R9: On `cfg_update`, if (cfg_max_depth + 1) × cfg_hi_active is greater than the current high-priority cap, `cfg_err` is 1 from the next cycle. A product equal to the cap does not set it.
- R10: On `cfg_update`, if (cfg_max_depth + 1) × cfg_lo_active is greater than the current low-priority cap, `cfg_err` is 1 from the next cycle. A product equal to the cap does not set it.
- R11: `cfg_err` is sticky. A later legal update leaves it set. `err_clear` clears it on the next edge. A failing update in the same cycle as `err_clear` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| budget_code | input | 2 | Class split: 0 open, 1 low-heavy, 2 high-heavy, 3 even |
| hi_alloc_valid | input | 1 | High-priority allocation request |
| hi_alloc_ready | output | 1 | High-priority class is below its cap |
| hi_release | input | 1 | High-priority entry freed |
| hi_count | output | $clog2(DEPTH+1) | High-priority occupancy |
| lo_alloc_valid | input | 1 | Low-priority allocation request |
| lo_alloc_ready | output | 1 | Low-priority class is below its cap |
| lo_release | input | 1 | Low-priority entry freed |
| lo_count | output | $clog2(DEPTH+1) | Low-priority occupancy |
| cfg_max_depth | input | MAXD_W | Per-channel maximum depth minus one |
| cfg_hi_active | input | CH_W | Active high-priority channels |
| cfg_lo_active | input | CH_W | Active low-priority channels |
| cfg_update | input | 1 | Evaluate the configuration this cycle |
| err_clear | input | 1 | Clear the sticky error flag |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
A corrupted occupancy counter shows up on the count ports on the edge after the faulty update. The class's ready output then flips at the wrong fill level, so a fill run that pushes past the cap exposes it within one cycle of the expected stop. A wrong cap decode shows as a count that settles at the wrong value. It also shows as a ready that stays high or drops early for the selected code. A broken legality or sticky path appears on `cfg_err` one cycle after the strobe that should have set or cleared it.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
  typedef enum logic [1:0] {
    BUD_OPEN     = 2'd0,
    BUD_LO_HEAVY = 2'd1,
    BUD_HI_HEAVY = 2'd2,
    BUD_EVEN     = 2'd3
  } budget_e;

  localparam int CLS_HI = 0;
  localparam int CLS_LO = 1;
  localparam int NUM_CLS = 2;
endpackage

// File: rtl/fbl_cap_decode.sv
module fbl_cap_decode
  import fbl_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]                      code_i,
  output logic [NUM_CLS-1:0][CNT_W-1:0]   cap_o
);
  localparam logic [CNT_W-1:0] QTR  = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TQTR = CNT_W'((DEPTH / 4) * 3);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  always_comb begin
    case (budget_e'(code_i))
      BUD_LO_HEAVY: begin
        cap_o[CLS_HI] = QTR;
        cap_o[CLS_LO] = TQTR;
      end
      BUD_HI_HEAVY: begin
        cap_o[CLS_HI] = TQTR;
        cap_o[CLS_LO] = QTR;
      end
      BUD_EVEN: begin
        cap_o[CLS_HI] = HALF;
        cap_o[CLS_LO] = HALF;
      end
      default: begin
        cap_o[CLS_HI] = FULL;
        cap_o[CLS_LO] = FULL;
      end
    endcase
  end
endmodule

// File: rtl/fbl_class_ctr.sv
module fbl_class_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cap_i,
  input  logic             valid_i,
  input  logic             release_i,
  output logic             ready_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             take;
  logic             give;

  assign ready_o = (cnt_q < cap_i);
  assign take    = valid_i & ready_o;
  assign give    = release_i & (cnt_q != '0);
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (take && release_i) begin
      cnt_q <= cnt_q;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (give) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fbl_cfg_check.sv
module fbl_cfg_check
  import fbl_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int MAXD_W = 6,
  parameter int CH_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CLS-1:0][CNT_W-1:0]   cap_i,
  input  logic [MAXD_W-1:0]               max_depth_i,
  input  logic [NUM_CLS-1:0][CH_W-1:0]    active_i,
  input  logic                            update_i,
  input  logic                            clear_i,
  output logic                            err_o
);
  localparam int NEED_W = MAXD_W + 1 + CH_W;
  localparam int CMP_W  = (NEED_W > CNT_W) ? NEED_W : CNT_W;

  logic [CMP_W-1:0]   per_chan;
  logic [NUM_CLS-1:0] over;
  logic               err_q;

  assign per_chan = CMP_W'(max_depth_i) + CMP_W'(1);

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_need
    logic [CMP_W-1:0] need;
    assign need    = per_chan * CMP_W'(active_i[c]);
    assign over[c] = need > CMP_W'(cap_i[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (update_i && (over != '0)) begin
      err_q <= 1'b1;
    end else if (clear_i) begin
      err_q <= 1'b0;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/fifo_budget_limiter.sv
module fifo_budget_limiter
  import fbl_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int MAXD_W = 6,
  parameter int CH_W   = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        budget_code,
  input  logic              hi_alloc_valid,
  output logic              hi_alloc_ready,
  input  logic              hi_release,
  output logic [CNT_W-1:0]  hi_count,
  input  logic              lo_alloc_valid,
  output logic              lo_alloc_ready,
  input  logic              lo_release,
  output logic [CNT_W-1:0]  lo_count,
  input  logic [MAXD_W-1:0] cfg_max_depth,
  input  logic [CH_W-1:0]   cfg_hi_active,
  input  logic [CH_W-1:0]   cfg_lo_active,
  input  logic              cfg_update,
  input  logic              err_clear,
  output logic              cfg_err
);
  logic [NUM_CLS-1:0][CNT_W-1:0] caps;
  logic [NUM_CLS-1:0][CNT_W-1:0] counts;
  logic [NUM_CLS-1:0]            valids;
  logic [NUM_CLS-1:0]            releases;
  logic [NUM_CLS-1:0]            readies;
  logic [NUM_CLS-1:0][CH_W-1:0]  actives;

  assign valids[CLS_HI]   = hi_alloc_valid;
  assign valids[CLS_LO]   = lo_alloc_valid;
  assign releases[CLS_HI] = hi_release;
  assign releases[CLS_LO] = lo_release;
  assign actives[CLS_HI]  = cfg_hi_active;
  assign actives[CLS_LO]  = cfg_lo_active;

  fbl_cap_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) cap_i (
    .code_i (budget_code),
    .cap_o  (caps)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    fbl_class_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (caps[c]),
      .valid_i   (valids[c]),
      .release_i (releases[c]),
      .ready_o   (readies[c]),
      .count_o   (counts[c])
    );
  end

  fbl_cfg_check #(.CNT_W(CNT_W), .MAXD_W(MAXD_W), .CH_W(CH_W)) chk_cfg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_i       (caps),
    .max_depth_i (cfg_max_depth),
    .active_i    (actives),
    .update_i    (cfg_update),
    .clear_i     (err_clear),
    .err_o       (cfg_err)
  );

  assign hi_alloc_ready = readies[CLS_HI];
  assign lo_alloc_ready = readies[CLS_LO];
  assign hi_count       = counts[CLS_HI];
  assign lo_count       = counts[CLS_LO];
endmodule

// File: rtl/fbl_checker.sv
module fbl_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       budget_code,
  input logic             hi_alloc_valid,
  input logic             hi_alloc_ready,
  input logic             hi_release,
  input logic [CNT_W-1:0] hi_count,
  input logic             lo_alloc_valid,
  input logic             lo_alloc_ready,
  input logic             lo_release,
  input logic [CNT_W-1:0] lo_count,
  input logic             cfg_update,
  input logic             err_clear,
  input logic             cfg_err
);
  localparam logic [CNT_W-1:0] QTR  = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TQTR = CNT_W'((DEPTH / 4) * 3);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  a_r2_hi_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (budget_code == 2'd1 && hi_count >= QTR) |-> !hi_alloc_ready);
  a_r2_lo_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (budget_code == 2'd1 && lo_count >= TQTR) |-> !lo_alloc_ready);
  a_r3_hi_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (budget_code == 2'd2 && hi_count >= TQTR) |-> !hi_alloc_ready);
  a_r3_lo_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (budget_code == 2'd2 && lo_count >= QTR) |-> !lo_alloc_ready);
  a_r4_even_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (budget_code == 2'd3 && (hi_count >= HALF || lo_count >= HALF)) |->
    !((hi_count >= HALF && hi_alloc_ready) || (lo_count >= HALF && lo_alloc_ready)));
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_count <= FULL) && (lo_count <= FULL));
  a_r6_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_count == '0) |-> hi_alloc_ready);
  a_r6_hi_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_alloc_valid && hi_alloc_ready && !hi_release) |=> hi_count == $past(hi_count) + 1'b1);
  a_r6_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lo_alloc_valid && lo_alloc_ready) && !lo_release) |=> $stable(lo_count));
  a_r7_hi_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_alloc_valid && hi_alloc_ready && hi_release) |=> $stable(hi_count));
  a_r7_lo_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_alloc_valid && lo_alloc_ready && lo_release) |=> $stable(lo_count));
  a_r8_hi_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_count == '0 && hi_release && !hi_alloc_valid) |=> hi_count == '0);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !err_clear) |=> cfg_err);
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !cfg_update) |=> !cfg_err);
endmodule

bind fifo_budget_limiter fbl_checker #(.DEPTH(DEPTH)) fbl_chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .budget_code    (budget_code),
  .hi_alloc_valid (hi_alloc_valid),
  .hi_alloc_ready (hi_alloc_ready),
  .hi_release     (hi_release),
  .hi_count       (hi_count),
  .lo_alloc_valid (lo_alloc_valid),
  .lo_alloc_ready (lo_alloc_ready),
  .lo_release     (lo_release),
  .lo_count       (lo_count),
  .cfg_update     (cfg_update),
  .err_clear      (err_clear),
  .cfg_err        (cfg_err)
);

// File: tb/fifo_budget_limiter_tb_top.sv
module fifo_budget_limiter_tb_top;
  localparam int DEPTH  = 64;
  localparam int MAXD_W = 6;
  localparam int CH_W   = 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        budget_code = 2'd0;
  logic              hi_alloc_valid = 1'b0, hi_release = 1'b0;
  logic              lo_alloc_valid = 1'b0, lo_release = 1'b0;
  logic              hi_alloc_ready, lo_alloc_ready, cfg_err;
  logic [CNT_W-1:0]  hi_count, lo_count;
  logic [MAXD_W-1:0] cfg_max_depth = '0;
  logic [CH_W-1:0]   cfg_hi_active = '0, cfg_lo_active = '0;
  logic              cfg_update = 1'b0, err_clear = 1'b0;

  always #4 clk = ~clk;

  fifo_budget_limiter #(.DEPTH(DEPTH), .MAXD_W(MAXD_W), .CH_W(CH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .budget_code(budget_code),
    .hi_alloc_valid(hi_alloc_valid), .hi_alloc_ready(hi_alloc_ready),
    .hi_release(hi_release), .hi_count(hi_count),
    .lo_alloc_valid(lo_alloc_valid), .lo_alloc_ready(lo_alloc_ready),
    .lo_release(lo_release), .lo_count(lo_count),
    .cfg_max_depth(cfg_max_depth), .cfg_hi_active(cfg_hi_active),
    .cfg_lo_active(cfg_lo_active), .cfg_update(cfg_update),
    .err_clear(err_clear), .cfg_err(cfg_err)
  );

  typedef struct {
    int    hi;
    int    lo;
    bit    err;
    bit    hrdy;
    bit    lrdy;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   m_hi = 0, m_lo = 0;
  bit   m_err = 0;
  bit   done = 0;

  function automatic int cap_of(int code, int cls);
    case (code)
      1: return (cls == 0) ? DEPTH / 4 : 3 * (DEPTH / 4);
      2: return (cls == 0) ? 3 * (DEPTH / 4) : DEPTH / 4;
      3: return DEPTH / 2;
      default: return DEPTH;
    endcase
  endfunction

  function automatic int next_cnt(int cnt, int cap, bit v, bit r);
    bit acc;
    acc = v && (cnt < cap);
    if (acc && r) return cnt;
    if (acc) return cnt + 1;
    if (r && cnt > 0) return cnt - 1;
    return cnt;
  endfunction

  // driver: called just after a falling edge; drives one cycle and predicts
  task automatic drive(input bit hv, input bit hr, input bit lv, input bit lr,
                       input bit upd, input bit clr, input string tag);
    exp_t e;
    int   ch, cl;
    bit   viol;
    hi_alloc_valid = hv; hi_release = hr;
    lo_alloc_valid = lv; lo_release = lr;
    cfg_update = upd; err_clear = clr;
    ch = cap_of(budget_code, 0);
    cl = cap_of(budget_code, 1);
    viol = ((cfg_max_depth + 1) * cfg_hi_active > ch) ||
           ((cfg_max_depth + 1) * cfg_lo_active > cl);
    m_hi = next_cnt(m_hi, ch, hv, hr);
    m_lo = next_cnt(m_lo, cl, lv, lr);
    if (upd && viol) m_err = 1;
    else if (clr) m_err = 0;
    e.hi = m_hi; e.lo = m_lo; e.err = m_err;
    e.hrdy = (m_hi < ch); e.lrdy = (m_lo < cl); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    hi_alloc_valid = 0; hi_release = 0; lo_alloc_valid = 0; lo_release = 0;
    cfg_update = 0; err_clear = 0;
  endtask

  task automatic set_code(input int code);
    budget_code = 2'(code);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < DEPTH + 2; i++) drive(0, 1, 0, 1, 0, 0, tag);
  endtask

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (int'(hi_count) != e.hi || int'(lo_count) != e.lo || cfg_err != e.err ||
          hi_alloc_ready != e.hrdy || lo_alloc_ready != e.lrdy) begin
        n_bad++;
        $display("FAIL %s: got hi=%0d lo=%0d err=%0b hrdy=%0b lrdy=%0b exp hi=%0d lo=%0d err=%0b hrdy=%0b lrdy=%0b",
                 e.tag, hi_count, lo_count, cfg_err, hi_alloc_ready, lo_alloc_ready,
                 e.hi, e.lo, e.err, e.hrdy, e.lrdy);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state right after reset
    drive(0, 0, 0, 0, 0, 0, "R1");

    // R2 code 1, R6 back-pressure past the cap
    set_code(1);
    for (int i = 0; i < DEPTH / 4 + 4; i++) drive(1, 0, 0, 0, 0, 0, "R2_R6 hi");
    for (int i = 0; i < 3 * DEPTH / 4 + 4; i++) drive(0, 0, 1, 0, 0, 0, "R2_R6 lo");
    drain("R8 drain");

    // R3 code 2
    set_code(2);
    for (int i = 0; i < 3 * DEPTH / 4 + 3; i++) drive(1, 0, 1, 0, 0, 0, "R3");
    drain("R8 drain");

    // R4 code 3, then R7 simultaneous allocate and release
    set_code(3);
    for (int i = 0; i < DEPTH / 2 + 3; i++) drive(1, 0, 1, 0, 0, 0, "R4");
    drain("R8 drain");
    for (int i = 0; i < 5; i++) drive(1, 0, 1, 0, 0, 0, "R6 partial");
    for (int i = 0; i < 3; i++) drive(1, 1, 1, 1, 0, 0, "R7");
    drain("R8 drain");
    drive(0, 1, 0, 1, 0, 0, "R8 at zero");
    drive(1, 1, 0, 1, 0, 0, "R7 pair at zero");

    // R5 code 0
    set_code(0);
    for (int i = 0; i < DEPTH + 3; i++) drive(1, 0, 1, 0, 0, 0, "R5");
    drain("R8 drain");

    // R9 high-class legality, code 3 (cap 32)
    set_code(3);
    cfg_max_depth = 6'd7; cfg_hi_active = 4'd4; cfg_lo_active = 4'd0;
    drive(0, 0, 0, 0, 1, 0, "R9 equal fits");
    cfg_hi_active = 4'd5;
    drive(0, 0, 0, 0, 1, 0, "R9 over");
    cfg_hi_active = 4'd1;
    drive(0, 0, 0, 0, 1, 0, "R11 sticky");
    drive(0, 0, 0, 0, 0, 1, "R11 clear");

    // R10 low-class legality, code 1 (cap 48)
    set_code(1);
    cfg_max_depth = 6'd15; cfg_hi_active = 4'd1; cfg_lo_active = 4'd3;
    drive(0, 0, 0, 0, 1, 0, "R10 equal fits");
    cfg_lo_active = 4'd4;
    drive(0, 0, 0, 0, 1, 1, "R10_R11 set wins over clear");
    drive(0, 0, 0, 0, 0, 0, "R11 held");
    drive(0, 0, 0, 0, 0, 1, "R11 clear");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule